// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight status bits of a small processor core in one register: the global interrupt enable, a single-bit transfer flag and six arithmetic flags (half carry, sign, overflow, negative, zero, carry). The execution unit writes arithmetic results through a masked update port. Each flag is loaded only when its mask bit is set. The interrupt logic sends pulses for acceptance and return. Separate commands set or clear the enable. Software can write or read the whole register in one access.

The transfer flag connects two bit operations. A store copies one indexed bit of an operand into the flag. A load returns an operand with the indexed bit replaced by the flag. The block also gates an external any-pending indication with the global enable. The result is the interrupt request seen by the core's sequencer.

The sign flag is never stored as written. It is always recomputed as negative XOR overflow, from the values those two flags take after the update.

Top module: `psr_status_reg`

## Requirements
- R1: After reset all eight register bits read 0, and the interrupt request output is 0.
- R2: Register bit positions, from bit 7 down to bit 0, are: global enable, transfer, half carry, sign, overflow, negative, zero, carry. A software write loads all bits from the write data except the sign bit, and the new value reads back on the cycle after the write.
- R3: The update mask and update value are 5 bits each, ordered half carry (bit 4), overflow (3), negative (2), zero (1), carry (0). A flag with mask bit 1 takes its update value. A flag with mask bit 0 keeps its value.
- R4: The stored sign bit always equals negative XOR overflow, whatever sign value software wrote.
- R5: The interrupt request output is combinational and equals the global enable AND the pending input. With the enable at 0 no request is forwarded.
- R6: An acceptance pulse clears the global enable on the next clock. It takes priority over a software write, a return pulse or a set command in the same cycle, so the request output drops in the cycle after acceptance.
- R7: A return pulse or a set command makes the global enable 1. A clear command makes it 0. When set and clear coincide, set wins.
- R8: A software write takes priority over return, set and clear, over masked flag updates, and over a bit store in the same cycle.
- R9: A bit-store pulse copies operand bit [index] into the transfer flag, with the index 3 bits wide.
- R10: The bit-load output is combinational and equals the operand with bit [index] replaced by the current transfer flag, all other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| upd_mask | input | 5 | Per-flag update enables (H,V,N,Z,C) |
| upd_flags | input | 5 | New flag values (H,V,N,Z,C) |
| irq_accept | input | 1 | Interrupt accepted pulse |
| irq_return | input | 1 | Return from interrupt pulse |
| ie_set | input | 1 | Set global enable command |
| ie_clr | input | 1 | Clear global enable command |
| bst_en | input | 1 | Bit-store command |
| xfer_operand | input | 8 | Operand for bit store and bit load |
| xfer_idx | input | 3 | Bit index for bit store and bit load |
| bld_result | output | 8 | Operand with indexed bit replaced by transfer flag |
| sw_we | input | 1 | Software whole-register write strobe |
| sw_wdata | input | 8 | Software write data |
| rd_data | output | 8 | Current register contents |
| irq_pending | input | 1 | Any enabled interrupt is pending |
| irq_req | output | 1 | Gated interrupt request |

## Verification
The collisions that matter are a software write and the other writers to the same bits. One vector asserts a software write together with a return pulse, a full flag update and a bit store. Another asserts a software write together with an acceptance pulse. Acceptance is also driven in the same cycle as a set command, and set in the same cycle as clear. Each outcome is judged on the register contents read back one clock later against the stated priority order, with the sign bit checked against negative XOR overflow and not against the written value.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned PSR_W  = 8;
  localparam int unsigned IDX_W  = $clog2(PSR_W);
  localparam int unsigned ARITH_W = 5;

  // Positions inside the 5-bit arithmetic update vector
  localparam int unsigned AF_H = 4;
  localparam int unsigned AF_V = 3;
  localparam int unsigned AF_N = 2;
  localparam int unsigned AF_Z = 1;
  localparam int unsigned AF_C = 0;

  // Field order is the register bit order, MSB first
  typedef struct packed {
    logic ie;
    logic t;
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } psr_t;
endpackage

// File: rtl/psr_ie_ctrl.sv
module psr_ie_ctrl (
  input  logic ie_q,
  input  logic accept,
  input  logic sw_we,
  input  logic sw_ie,
  input  logic ret,
  input  logic set,
  input  logic clr,
  input  logic pending,
  output logic ie_en,
  output logic ie_d,
  output logic irq_req
);
  always_comb begin
    ie_en = accept | sw_we | ret | set | clr;
    ie_d  = ie_q;
    if (accept)          ie_d = 1'b0;
    else if (sw_we)      ie_d = sw_ie;
    else if (ret || set) ie_d = 1'b1;
    else if (clr)        ie_d = 1'b0;
  end

  assign irq_req = ie_q & pending;
endmodule

// File: rtl/psr_bitxfer.sv
module psr_bitxfer #(
  parameter int unsigned W    = 8,
  parameter int unsigned IDXW = $clog2(W)
) (
  input  logic            t_q,
  input  logic [W-1:0]    operand,
  input  logic [IDXW-1:0] idx,
  input  logic            bst_en,
  input  logic            sw_we,
  input  logic            sw_t,
  output logic            t_en,
  output logic            t_d,
  output logic [W-1:0]    bld_result
);
  logic [W-1:0] hit;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign hit[g]        = (idx == IDXW'(g));
    assign bld_result[g] = hit[g] ? t_q : operand[g];
  end

  always_comb begin
    t_en = sw_we | bst_en;
    t_d  = t_q;
    if (sw_we)       t_d = sw_t;
    else if (bst_en) t_d = |(operand & hit);
  end
endmodule

// File: rtl/psr_arith_flags.sv
module psr_arith_flags #(
  parameter int unsigned AW  = 5,
  parameter int unsigned POS_V = 3,
  parameter int unsigned POS_N = 2
) (
  input  logic [AW-1:0] flags_q,
  input  logic [AW-1:0] upd_mask,
  input  logic [AW-1:0] upd_val,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_val,
  output logic [AW-1:0] flags_en,
  output logic [AW-1:0] flags_d,
  output logic          sign_en,
  output logic          sign_d
);
  logic [AW-1:0] flags_nx;

  for (genvar g = 0; g < AW; g++) begin : g_flag
    assign flags_en[g] = sw_we | upd_mask[g];
    assign flags_d[g]  = sw_we ? sw_val[g] : upd_val[g];
    assign flags_nx[g] = flags_en[g] ? flags_d[g] : flags_q[g];
  end

  assign sign_en = flags_en[POS_V] | flags_en[POS_N];
  assign sign_d  = flags_nx[POS_V] ^ flags_nx[POS_N];
endmodule

// File: rtl/psr_status_reg.sv
module psr_status_reg
  import psr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ARITH_W-1:0]   upd_mask,
  input  logic [ARITH_W-1:0]   upd_flags,
  input  logic                 irq_accept,
  input  logic                 irq_return,
  input  logic                 ie_set,
  input  logic                 ie_clr,
  input  logic                 bst_en,
  input  logic [PSR_W-1:0]     xfer_operand,
  input  logic [IDX_W-1:0]     xfer_idx,
  output logic [PSR_W-1:0]     bld_result,
  input  logic                 sw_we,
  input  logic [PSR_W-1:0]     sw_wdata,
  output logic [PSR_W-1:0]     rd_data,
  input  logic                 irq_pending,
  output logic                 irq_req
);
  psr_t psr_q;
  psr_t sw_word;

  logic               ie_en, ie_d;
  logic               t_en, t_d;
  logic [ARITH_W-1:0] af_q, af_en, af_d, sw_af;
  logic               s_en, s_d;

  assign sw_word = psr_t'(sw_wdata);
  assign af_q  = {psr_q.h, psr_q.v, psr_q.n, psr_q.z, psr_q.c};
  assign sw_af = {sw_word.h, sw_word.v, sw_word.n, sw_word.z, sw_word.c};

  psr_ie_ctrl u_ie (
    .ie_q    (psr_q.ie),
    .accept  (irq_accept),
    .sw_we   (sw_we),
    .sw_ie   (sw_word.ie),
    .ret     (irq_return),
    .set     (ie_set),
    .clr     (ie_clr),
    .pending (irq_pending),
    .ie_en   (ie_en),
    .ie_d    (ie_d),
    .irq_req (irq_req)
  );

  psr_bitxfer #(.W(PSR_W), .IDXW(IDX_W)) u_xfer (
    .t_q        (psr_q.t),
    .operand    (xfer_operand),
    .idx        (xfer_idx),
    .bst_en     (bst_en),
    .sw_we      (sw_we),
    .sw_t       (sw_word.t),
    .t_en       (t_en),
    .t_d        (t_d),
    .bld_result (bld_result)
  );

  psr_arith_flags #(.AW(ARITH_W), .POS_V(AF_V), .POS_N(AF_N)) u_af (
    .flags_q  (af_q),
    .upd_mask (upd_mask),
    .upd_val  (upd_flags),
    .sw_we    (sw_we),
    .sw_val   (sw_af),
    .flags_en (af_en),
    .flags_d  (af_d),
    .sign_en  (s_en),
    .sign_d   (s_d)
  );

  // Register process with explicit per-bit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psr_q <= '0;
    end else begin
      if (ie_en)       psr_q.ie <= ie_d;
      if (t_en)        psr_q.t  <= t_d;
      if (af_en[AF_H]) psr_q.h  <= af_d[AF_H];
      if (s_en)        psr_q.s  <= s_d;
      if (af_en[AF_V]) psr_q.v  <= af_d[AF_V];
      if (af_en[AF_N]) psr_q.n  <= af_d[AF_N];
      if (af_en[AF_Z]) psr_q.z  <= af_d[AF_Z];
      if (af_en[AF_C]) psr_q.c  <= af_d[AF_C];
    end
  end

  assign rd_data = psr_q;

  // R4: sign bit consistent with negative and overflow
  p_sign_xor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] == (rd_data[3] ^ rd_data[2]));

  // R6: acceptance clears the enable and drops the request
  p_accept_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |=> (!rd_data[7] && !irq_req));

  // R7: return with no higher-priority event sets the enable
  p_return_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !irq_accept && !sw_we) |=> rd_data[7]);

  // R3: unmasked carry holds its value
  p_carry_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !upd_mask[AF_C]) |=> $stable(rd_data[0]));

  // R9: bit store captures the indexed operand bit
  p_bit_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_en && !sw_we) |=> rd_data[6] == $past(xfer_operand[xfer_idx]));

  // R8: software write wins over the enable commands
  p_sw_over_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !irq_accept) |=> rd_data[7] == $past(sw_wdata[7]));
endmodule

// File: tb/psr_status_reg_tb_top.sv
module psr_status_reg_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 5000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] upd_mask, upd_flags;
  logic       irq_accept, irq_return, ie_set, ie_clr, bst_en;
  logic [7:0] xfer_operand;
  logic [2:0] xfer_idx;
  logic [7:0] bld_result;
  logic       sw_we;
  logic [7:0] sw_wdata;
  logic [7:0] rd_data;
  logic       irq_pending, irq_req;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_status_reg dut_i (
    .clk, .rst_n, .upd_mask, .upd_flags, .irq_accept, .irq_return,
    .ie_set, .ie_clr, .bst_en, .xfer_operand, .xfer_idx, .bld_result,
    .sw_we, .sw_wdata, .rd_data, .irq_pending, .irq_req
  );

  typedef struct packed {
    logic       we;
    logic [7:0] wd;
    logic [4:0] ue;
    logic [4:0] uf;
    logic       set;
    logic       clr;
    logic       ret;
    logic       acc;
    logic       bst;
    logic [7:0] op;
    logic [2:0] idx;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 15;
  // Each row applied for one clock from the state left by the previous row
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'hFF, 5'b00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 8'hEF}, // R2 R4
    '{1'b0, 8'h00, 5'b11111, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 8'hC0}, // R3
    '{1'b0, 8'h00, 5'b00100, 5'b00100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 8'hD4}, // R4
    '{1'b0, 8'h00, 5'b01000, 5'b01000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 8'hCC}, // R4
    '{1'b0, 8'h00, 5'b00011, 5'b00001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 8'hCD}, // R3
    '{1'b0, 8'h00, 5'b00000, 5'b11111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 8'hCD}, // R3
    '{1'b0, 8'h00, 5'b00000, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 3'd0, 8'h4D}, // R6
    '{1'b0, 8'h00, 5'b00000, 5'b00000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 3'd0, 8'hCD}, // R7
    '{1'b0, 8'h00, 5'b00000, 5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 8'h4D}, // R7
    '{1'b0, 8'h00, 5'b00000, 5'b00000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 8'hCD}, // R7
    '{1'b0, 8'h00, 5'b00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 3'd6, 8'h8D}, // R9
    '{1'b0, 8'h00, 5'b00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h08, 3'd3, 8'hCD}, // R9
    '{1'b1, 8'h10, 5'b11111, 5'b11111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 3'd0, 8'h00}, // R8
    '{1'b1, 8'h84, 5'b00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 3'd0, 8'h14}, // R6
    '{1'b1, 8'h08, 5'b00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 8'h18}  // R2 R4
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    upd_mask = '0; upd_flags = '0; irq_accept = 0; irq_return = 0;
    ie_set = 0; ie_clr = 0; bst_en = 0; xfer_operand = '0; xfer_idx = '0;
    sw_we = 0; sw_wdata = '0;
  endtask

  task automatic sw_write(input logic [7:0] d);
    @(negedge clk);
    sw_we = 1; sw_wdata = d;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin : stim
    idle_inputs();
    irq_pending = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset rd_data", rd_data, 8'h00);
    check("R1 reset irq_req", {7'd0, irq_req}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", rd_data, 8'h00);

    for (int i = 0; i < NV; i++) begin
      sw_we = VECS[i].we; sw_wdata = VECS[i].wd;
      upd_mask = VECS[i].ue; upd_flags = VECS[i].uf;
      ie_set = VECS[i].set; ie_clr = VECS[i].clr;
      irq_return = VECS[i].ret; irq_accept = VECS[i].acc;
      bst_en = VECS[i].bst; xfer_operand = VECS[i].op; xfer_idx = VECS[i].idx;
      @(negedge clk);
      idle_inputs();
      check($sformatf("R2-table row %0d", i), rd_data, VECS[i].exp);
    end

    // R5: request gating
    sw_write(8'h80);
    irq_pending = 1; #1;
    check("R5 enabled+pending", {7'd0, irq_req}, 8'h01);
    irq_pending = 0; #1;
    check("R5 enabled no pending", {7'd0, irq_req}, 8'h00);
    sw_write(8'h00);
    irq_pending = 1; #1;
    check("R5 disabled pending", {7'd0, irq_req}, 8'h00);

    // R6: request drops in cycle after acceptance
    sw_write(8'h80);
    #1;
    check("R6 before accept", {7'd0, irq_req}, 8'h01);
    irq_accept = 1;
    @(negedge clk);
    irq_accept = 0; #1;
    check("R6 after accept", {7'd0, irq_req}, 8'h00);
    check("R6 enable bit", rd_data, 8'h00);

    // R10: bit load, T=1 then T=0, every index
    sw_write(8'h40);
    for (int k = 0; k < 8; k++) begin
      xfer_operand = 8'h00; xfer_idx = 3'(k); #1;
      check($sformatf("R10 T1 idx %0d", k), bld_result, 8'(1 << k));
    end
    sw_write(8'h00);
    for (int k = 0; k < 8; k++) begin
      xfer_operand = 8'hFF; xfer_idx = 3'(k); #1;
      check($sformatf("R10 T0 idx %0d", k), bld_result, ~8'(1 << k));
    end
    xfer_operand = 8'h5A; xfer_idx = 3'd1; #1;
    check("R10 mixed operand", bld_result, 8'h58);

    // R9: bit store of bit 7 from a sparse operand
    @(negedge clk);
    bst_en = 1; xfer_operand = 8'h80; xfer_idx = 3'd7;
    @(negedge clk);
    idle_inputs();
    check("R9 store bit 7", rd_data, 8'h40);

    // R1: mid-run reset
    sw_write(8'hEF);
    rst_n = 0; #1;
    check("R1 async reset", rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule